// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block is a small, fully associative store of page-table entries that turns a virtual address into a physical address in the same clock cycle it is presented. Every entry holds a virtual page number as its key, a process tag, a physical frame number and four status flags: valid, writable, referenced and dirty. A lookup succeeds only when the page number matches, the entry is valid, and the entry's tag equals the current process value. The result is formed by replacing the upper address bits with the stored frame number. The low 12 offset bits pass through unchanged.

When no entry matches, the block raises a miss fault in the same cycle, so that an external refill agent can fetch the mapping. The agent installs the mapping through a valid/ready fill port. A store to a page without write permission raises a protection fault instead of a hit. Two context-switch controls are provided. One empties every entry. The other clears only the valid flags. Because entries are tagged with the process value, a switch between processes may also be done with neither control.

Back-pressure on the fill port is simple. `fill_ready` drops only in a cycle where `flush_all` or `ctx_inval` is high. A fill is taken on a rising edge where both `fill_valid` and `fill_ready` are high. The lookup side has no handshake: it answers combinationally in every cycle.

Top module: `tlb_xlat`

## Requirements
- R1: While `lk_valid` is high and a valid entry has the page number `lk_vaddr[31:12]` and the tag `cur_pid`, `lk_hit` rises in the same cycle. `lk_paddr` then equals {frame[19:0], `lk_vaddr[11:0]`}. When `lk_hit` is low, `lk_paddr` is zero.
- R2: An entry whose tag differs from `cur_pid` never produces a hit, even if its page number matches.
- R3: While `lk_valid` is high and no valid entry matches both page number and tag, `miss_fault` is high in the same cycle and `lk_hit` is low.
- R4: A matching lookup with `lk_store` high, against an entry whose writable flag is 0, drives `prot_fault` high. In that case `lk_hit` and `miss_fault` are both low.
- R5: `lk_dirty`, `lk_ref` and `lk_writable` show the matched entry's flags as they stood before the current cycle, and are zero when nothing matches. A hit sets the referenced flag at the clock edge. A hit with `lk_store` high also sets the dirty flag.
- R6: `fill_ready` is low exactly in cycles where `flush_all` or `ctx_inval` is high. An accepted fill stores the entry with valid set, referenced and dirty clear, and writable taken from `fill_writable`. The entry can be hit from the next cycle.
- R7: The slot for a fill is chosen as follows:
  - a valid entry with the same page number and tag is overwritten, so no duplicate is ever created;
  - otherwise the lowest-index invalid slot is used;
  - otherwise a round-robin pointer selects the slot. The pointer starts at slot 0 after reset and advances by one, modulo the entry count, on each fill that uses it.
- R8: `flush_all` empties every entry and returns the round-robin pointer to slot 0. Every lookup misses from the next cycle until new fills arrive.
- R9: `ctx_inval` clears only the valid flags and leaves the round-robin pointer unchanged. Every lookup misses from the next cycle.
- R10: If a fill replaces an entry that a lookup hits in the same cycle, the fill wins. The old mapping is gone in the next cycle and the new mapping hits.
- R11: While `lk_valid` is low, `lk_hit`, `miss_fault` and `prot_fault` stay low, and no flag is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pid | input | 8 | Current process tag compared on every lookup |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Translation succeeded |
| lk_paddr | output | 32 | Translated physical address |
| lk_dirty | output | 1 | Dirty flag of the matched entry |
| lk_ref | output | 1 | Referenced flag of the matched entry |
| lk_writable | output | 1 | Writable flag of the matched entry |
| miss_fault | output | 1 | No matching entry |
| prot_fault | output | 1 | Store to a read-only page |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill request can be taken |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_pid | input | 8 | Process tag of the new entry |
| fill_pfn | input | 20 | Frame number of the new entry |
| fill_writable | input | 1 | Writable flag of the new entry |
| flush_all | input | 1 | Empty every entry |
| ctx_inval | input | 1 | Clear every valid flag |

## Verification
Two functions can land in the same cycle and interact: a lookup that updates the referenced or dirty flag, and a fill that writes the slot being hit. The bench provokes this directly. It fills every slot, lets the round-robin pointer land on a known slot, then presents a lookup that hits that slot together with a fill of a new page. A reference model in the bench predicts that the lookup reports a hit in that cycle, the old page misses in the next cycle, and the new page hits. A long random phase also overlaps fills, lookups, flushes and invalidations, and checks every cycle against the same model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = 20;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int PID_W = 8;

  typedef struct packed {
    logic             v;
    logic             d;
    logic             r;
    logic             w;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  tlb_entry_t       tab [ENTRIES],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PID_W-1:0] key_pid,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = tab[g].v && (tab[g].vpn == key_vpn) && (tab[g].pid == key_pid);
  end

  // lowest index wins when several slots agree
  always_comb begin
    found = |eq;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               advance,
  input  logic [ENTRIES-1:0] valid,
  input  logic               key_found,
  input  logic [IDX_W-1:0]   key_idx,
  output logic [IDX_W-1:0]   victim,
  output logic               use_ptr
);
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &valid;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign use_ptr = !key_found && all_full;
  assign victim  = key_found ? key_idx : (all_full ? ptr : free_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clear) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cur_pid,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic [31:0]      lk_paddr,
  output logic             lk_dirty,
  output logic             lk_ref,
  output logic             lk_writable,
  output logic             miss_fault,
  output logic             prot_fault,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [19:0]      fill_vpn,
  input  logic [7:0]       fill_pid,
  input  logic [19:0]      fill_pfn,
  input  logic             fill_writable,
  input  logic             flush_all,
  input  logic             ctx_inval
);
  tlb_entry_t         tab [ENTRIES];
  logic [ENTRIES-1:0] vbits;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vb
    assign vbits[g] = tab[g].v;
  end

  // lookup path
  logic             lk_found_raw;
  logic [IDX_W-1:0] lk_idx;
  tlb_entry_t       sel;
  logic             lk_found;

  tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .tab     (tab),
    .key_vpn (lk_vaddr[VA_W-1:OFF_W]),
    .key_pid (cur_pid),
    .found   (lk_found_raw),
    .idx     (lk_idx)
  );

  assign sel         = tab[lk_idx];
  assign lk_found    = lk_valid && lk_found_raw;
  assign prot_fault  = lk_found && lk_store && !sel.w;
  assign lk_hit      = lk_found && !prot_fault;
  assign miss_fault  = lk_valid && !lk_found_raw;
  assign lk_paddr    = lk_hit ? {sel.pfn, lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_dirty    = lk_found && sel.d;
  assign lk_ref      = lk_found && sel.r;
  assign lk_writable = lk_found && sel.w;

  // fill path
  logic             fk_found;
  logic [IDX_W-1:0] fk_idx;
  logic [IDX_W-1:0] victim;
  logic             use_ptr;
  logic             fill_go;

  assign fill_ready = !flush_all && !ctx_inval;
  assign fill_go    = fill_valid && fill_ready;

  tlb_match #(.ENTRIES(ENTRIES)) u_fill_match (
    .tab     (tab),
    .key_vpn (fill_vpn),
    .key_pid (fill_pid),
    .found   (fk_found),
    .idx     (fk_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush_all),
    .advance   (fill_go && use_ptr),
    .valid     (vbits),
    .key_found (fk_found),
    .key_idx   (fk_idx),
    .victim    (victim),
    .use_ptr   (use_ptr)
  );

  // storage: flush > invalidate > fill > flag update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all) begin
          tab[i] <= '0;
        end else if (ctx_inval) begin
          tab[i].v <= 1'b0;
        end else if (fill_go && victim == IDX_W'(i)) begin
          tab[i].v   <= 1'b1;
          tab[i].d   <= 1'b0;
          tab[i].r   <= 1'b0;
          tab[i].w   <= fill_writable;
          tab[i].pid <= fill_pid;
          tab[i].vpn <= fill_vpn;
          tab[i].pfn <= fill_pfn;
        end else if (lk_hit && lk_idx == IDX_W'(i)) begin
          tab[i].r <= 1'b1;
          if (lk_store) tab[i].d <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cur_pid,
  input logic        lk_valid,
  input logic [31:0] lk_vaddr,
  input logic        lk_store,
  input logic        lk_hit,
  input logic [31:0] lk_paddr,
  input logic        lk_writable,
  input logic        miss_fault,
  input logic        prot_fault,
  input logic        fill_valid,
  input logic        fill_ready,
  input logic [19:0] fill_vpn,
  input logic [7:0]  fill_pid,
  input logic [19:0] fill_pfn,
  input logic        flush_all,
  input logic        ctx_inval
);
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

  assert_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fault |-> (!lk_hit && !prot_fault));

  assert_prot_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (lk_store && !lk_writable && !lk_hit));

  assert_fill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=>
      ((lk_valid && !lk_store && lk_vaddr[31:12] == $past(fill_vpn) && cur_pid == $past(fill_pid))
        -> (lk_hit && lk_paddr[31:12] == $past(fill_pfn))));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit && !prot_fault);

  assert_inval_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_inval |=> !lk_hit && !prot_fault);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !miss_fault && !prot_fault));
endmodule

bind tlb_xlat tlb_xlat_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cur_pid     (cur_pid),
  .lk_valid    (lk_valid),
  .lk_vaddr    (lk_vaddr),
  .lk_store    (lk_store),
  .lk_hit      (lk_hit),
  .lk_paddr    (lk_paddr),
  .lk_writable (lk_writable),
  .miss_fault  (miss_fault),
  .prot_fault  (prot_fault),
  .fill_valid  (fill_valid),
  .fill_ready  (fill_ready),
  .fill_vpn    (fill_vpn),
  .fill_pid    (fill_pid),
  .fill_pfn    (fill_pfn),
  .flush_all   (flush_all),
  .ctx_inval   (ctx_inval)
);

// File: tb/tlb_xlat_tb_top.sv
module tlb_xlat_tb_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cur_pid;
  logic        lk_valid, lk_store;
  logic [31:0] lk_vaddr;
  logic        lk_hit, lk_dirty, lk_ref, lk_writable, miss_fault, prot_fault;
  logic [31:0] lk_paddr;
  logic        fill_valid, fill_ready, fill_writable, flush_all, ctx_inval;
  logic [19:0] fill_vpn, fill_pfn;
  logic [7:0]  fill_pid;

  int checks = 0;
  int errors = 0;

  // reference model
  bit        m_v [N];
  bit        m_d [N];
  bit        m_r [N];
  bit        m_w [N];
  bit [7:0]  m_pid [N];
  bit [19:0] m_vpn [N];
  bit [19:0] m_pfn [N];
  int        m_ptr;

  always #5 clk = ~clk;

  tlb_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .cur_pid(cur_pid), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_store(lk_store), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
    .lk_writable(lk_writable), .miss_fault(miss_fault), .prot_fault(prot_fault),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pid(fill_pid), .fill_pfn(fill_pfn), .fill_writable(fill_writable),
    .flush_all(flush_all), .ctx_inval(ctx_inval)
  );

  function automatic int find(bit [19:0] vpn, bit [7:0] pid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    return -1;
  endfunction

  function automatic int pick_victim(bit [19:0] vpn, bit [7:0] pid, output bit used_ptr);
    int k;
    used_ptr = 1'b0;
    k = find(vpn, pid);
    if (k >= 0) return k;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    used_ptr = 1'b1;
    return m_ptr;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive, check combinational outputs, then update the model at the edge.
  task automatic step(bit lv, bit [19:0] vpn, bit [11:0] off, bit [7:0] pid, bit st,
                      bit fv, bit [19:0] fvpn, bit [7:0] fpid, bit [19:0] fpfn, bit fw,
                      bit fl, bit inv, string tag);
    int  li;
    bit  e_found, e_prot, e_hit, e_miss, e_rdy, used_ptr;
    int  vic;
    logic [38:0] exp_v, act_v;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = {vpn, off}; cur_pid = pid; lk_store = st;
    fill_valid = fv; fill_vpn = fvpn; fill_pid = fpid; fill_pfn = fpfn; fill_writable = fw;
    flush_all = fl; ctx_inval = inv;
    #1;
    li      = find(vpn, pid);
    e_found = lv && li >= 0;
    e_prot  = e_found && st && !m_w[li];
    e_hit   = e_found && !e_prot;
    e_miss  = lv && li < 0;
    e_rdy   = !fl && !inv;
    exp_v = {e_hit, e_miss, e_prot,
             e_found ? m_d[li] : 1'b0, e_found ? m_r[li] : 1'b0, e_found ? m_w[li] : 1'b0,
             e_hit ? {m_pfn[li], off} : 32'h0, e_rdy};
    act_v = {lk_hit, miss_fault, prot_fault, lk_dirty, lk_ref, lk_writable, lk_paddr, fill_ready};
    check(tag, 64'(act_v), 64'(exp_v));
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) begin
        m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0; m_pid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
      end
      m_ptr = 0;
    end else if (inv) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      vic = -1;
      if (fv) begin
        vic = pick_victim(fvpn, fpid, used_ptr);
        if (used_ptr) m_ptr = (m_ptr + 1) % N;
      end
      if (e_hit && li != vic) begin
        m_r[li] = 1;
        if (st) m_d[li] = 1;
      end
      if (vic >= 0) begin
        m_v[vic] = 1; m_d[vic] = 0; m_r[vic] = 0; m_w[vic] = fw;
        m_pid[vic] = fpid; m_vpn[vic] = fvpn; m_pfn[vic] = fpfn;
      end
    end
  endtask

  task automatic look(bit [19:0] vpn, bit [7:0] pid, bit st, string tag);
    step(1, vpn, 12'h5A3, pid, st, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(bit [19:0] vpn, bit [7:0] pid, bit [19:0] pfn, bit w, string tag);
    step(0, 0, 0, 0, 0, 1, vpn, pid, pfn, w, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit lv, st, fv, fw, fl, inv;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0; m_pid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
    end
    m_ptr = 0;
    rst_n = 0; cur_pid = 0; lk_valid = 0; lk_vaddr = 0; lk_store = 0;
    fill_valid = 0; fill_vpn = 0; fill_pid = 0; fill_pfn = 0; fill_writable = 0;
    flush_all = 0; ctx_inval = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // reset state: empty buffer misses (R3), idle lookup is quiet (R11)
    look(20'h00005, 8'h11, 0, "R3 reset miss");
    step(0, 20'h00005, 0, 8'h11, 1, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
    // fill and lookup in the same cycle: not yet visible (R6)
    step(1, 20'h00005, 12'h123, 8'h11, 0, 1, 20'h00005, 8'h11, 20'hABCDE, 1, 0, 0, "R6 fill not yet visible");
    look(20'h00005, 8'h11, 0, "R1 hit, R5 ref shown before update");
    look(20'h00005, 8'h11, 0, "R5 ref set");
    look(20'h00005, 8'h11, 1, "R5 store hit");
    look(20'h00005, 8'h11, 0, "R5 dirty set");
    look(20'h00005, 8'h22, 0, "R2 other tag misses");
    fill(20'h00007, 8'h11, 20'h00777, 0, "R6 read-only fill");
    look(20'h00007, 8'h11, 1, "R4 store to read-only");
    look(20'h00007, 8'h11, 0, "R4 load to read-only hits");
    fill(20'h00005, 8'h11, 20'h11111, 1, "R7 refill same key");
    look(20'h00005, 8'h11, 0, "R7 no duplicate, newest frame");
    step(1, 20'h00005, 0, 8'h11, 0, 1, 20'h00009, 8'h11, 20'h99999, 1, 0, 1, "R6 ready low with R9 invalidate");
    look(20'h00005, 8'h11, 0, "R9 miss after invalidate");
    look(20'h00009, 8'h11, 0, "R6 refused fill absent");
    // fill every slot, then wrap the pointer
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 flush");
    for (int i = 0; i < N; i++) fill(20'(100 + i), 8'h11, 20'(16'hF000 + i), 1, "R7 fill free slot");
    fill(20'd200, 8'h11, 20'h0C8C8, 1, "R7 pointer fill");
    look(20'd100, 8'h11, 0, "R7 slot 0 replaced");
    look(20'd101, 8'h11, 0, "R7 slot 1 intact");
    // hit on slot 1 while a fill replaces slot 1
    step(1, 20'd101, 12'h0, 8'h11, 1, 1, 20'd201, 8'h11, 20'h0C9C9, 1, 0, 0, "R10 hit and replace same cycle");
    look(20'd101, 8'h11, 0, "R10 old mapping gone");
    look(20'd201, 8'h11, 0, "R10 new mapping hits");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 flush");
    look(20'd201, 8'h11, 0, "R8 miss after flush");

    // constrained random against the model
    void'($urandom(32'd4242));
    for (int n = 0; n < 4000; n++) begin
      lv  = ($urandom % 4) != 0;
      st  = ($urandom % 3) == 0;
      fv  = ($urandom % 3) == 0;
      fw  = ($urandom % 4) != 0;
      fl  = ($urandom % 200) == 0;
      inv = ($urandom % 150) == 0;
      step(lv, 20'($urandom % 80), 12'($urandom), 8'(1 + $urandom % 3), st,
           fv, 20'($urandom % 80), 8'(1 + $urandom % 3), 20'($urandom), fw, fl, inv,
           "R1/R3/R4/R5/R7/R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule